// File: doc/BRIEF.md
# Page-offset-indexed set-associative cache lookup

This block is the lookup path of a set-associative data cache. The set index and the byte offset within a line come only from the untranslated low bits of the virtual address, the bits that are the same in the virtual and the physical address. The tag and data arrays can therefore be read in the same cycle in which a small fully associative translation buffer maps the virtual page number to a physical page number. In the following cycle the stored physical tags of every way are compared against that translated page number, and the hit or miss is reported from a registered output.

Because the index never uses translated bits, one way can hold at most one page of data. With the default 4 KiB page and 16-byte lines there are 256 sets, and each way holds 4 KiB. Capacity beyond one page comes from adding ways. Two virtual pages that map to the same physical page find the same cached line. A translation miss is reported at once. The request is then held inside the block and replayed automatically after a translation has been written through the fill port. Line refills arrive through a separate port that writes a whole line into the way chosen by a one-bit-per-set LRU.

Top module: `vipt_cache`

## Requirements
- R1: After reset, resp_valid is 0 and req_ready is 1. No translation and no cache line is valid, so the first lookup reports a translation miss, and the first lookup after a translation fill reports a cache miss.
- R2: A request accepted on a rising edge (req_valid and req_ready both 1) gets exactly one response. resp_valid is 0 after the first following edge and 1 after the second.
- R3: The set index is vaddr[11:4] and the word within the line is vaddr[3:2]. The upper virtual bits only select the translation. Two virtual pages translated to the same physical page hit the same line and return the same data.
- R4: A hit needs a translation hit and a valid way whose stored physical tag equals the translated page number. A line of another physical page in the same set gives resp_miss.
- R5: On a translation miss the response has resp_tlb_miss=1, with resp_hit=0 and resp_miss=0. req_ready then stays 0 and the request is held. The cycle after a translation fill, it is replayed with no new request, and its response follows two edges later. Exactly one of resp_hit, resp_miss and resp_tlb_miss is 1 with each response.
- R6: The translation buffer has 8 fully associative entries. A fill whose page number is already present overwrites that entry. Otherwise the fill goes to the lowest-numbered free entry. When all entries are full, replacements rotate through the entries starting at entry 0, advancing by one per replacement.
- R7: A line fill takes the line address paddr[31:4]. It writes the set paddr[11:4] with tag paddr[31:12] into the way named by that set's LRU bit. Word k of the line lies at data bits [32k+31:32k].
- R8: A hit marks its way as most recently used, and so does a line fill. With two lines in a set, the next fill replaces the one touched less recently.
- R9: A write that hits updates the 32-bit word at vaddr[3:2] in the hitting way, and its response carries resp_rdata=0. A write that misses changes no line and allocates nothing.
- R10: req_ready is 0 in the cycle after a write is accepted and in any cycle with line_fill_valid=1.
- R11: resp_rdata is 0 unless a read hits. resp_paddr is {physical page, vaddr[11:0]} when translated, and 0 on a translation miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 = store of req_wdata, 0 = load |
| req_wdata | input | 32 | Store data |
| tlb_fill_valid | input | 1 | Write a translation |
| tlb_fill_vpn | input | 20 | Virtual page number to install |
| tlb_fill_ppn | input | 20 | Physical page number it maps to |
| line_fill_valid | input | 1 | Write a cache line |
| line_fill_laddr | input | 28 | Physical line address (paddr[31:4]) |
| line_fill_data | input | 128 | Line contents, word k at bits [32k+31:32k] |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Cache hit |
| resp_miss | output | 1 | Translated, but no matching line |
| resp_tlb_miss | output | 1 | No translation for the page |
| resp_rdata | output | 32 | Load data on a read hit, else 0 |
| resp_paddr | output | 32 | Translated physical address, 0 on translation miss |

## Verification
A stale or wrong translation entry appears on the very next response to that page: resp_paddr or the hit flag is wrong two edges after the request. A corrupted LRU bit stays invisible until the next line fill into that set, when the wrong line survives and a later read of it turns from hit into miss. A lost hold state shows as req_ready returning high, or as no replay response, within three edges of the translation fill. A write that reaches the wrong word or way only surfaces on a later read of the neighbouring word or of a synonym page.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;

  // request hold / replay control
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_REPLAY = 2'd2
  } hold_st_t;

  // rotating successor used for LRU and replacement pointers
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/vipt_tlb.sv
`timescale 1ns/1ps
module vipt_tlb
  import vipt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [PW-1:0]      rr_q;
  logic [PW-1:0]      slot;
  logic               fl_found;
  logic               free_found;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e] = ent_v[e] && (ent_vpn[e] == lk_vpn);
    assign fl_match[e] = ent_v[e] && (ent_vpn[e] == fill_vpn);
  end

  // lookup: at most one entry matches, so an OR merge is enough
  always_comb begin
    lk_hit = |lk_match;
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (lk_match[e]) lk_ppn = lk_ppn | ent_ppn[e];
  end

  // fill slot: same page first, then lowest free entry, then rotating victim
  always_comb begin
    slot       = rr_q;
    fl_found   = 1'b0;
    free_found = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (!fl_found && fl_match[e]) begin
        slot     = PW'(e);
        fl_found = 1'b1;
      end
    if (!fl_found)
      for (int e = 0; e < ENTRIES; e++)
        if (!free_found && !ent_v[e]) begin
          slot       = PW'(e);
          free_found = 1'b1;
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v <= '0;
      rr_q  <= '0;
    end else if (fill_valid) begin
      ent_v[slot]   <= 1'b1;
      ent_vpn[slot] <= fill_vpn;
      ent_ppn[slot] <= fill_ppn;
      if (!fl_found && !free_found)
        rr_q <= PW'(wrap_inc(int'(rr_q), ENTRIES));
    end
  end

  // R6: a page number is never installed twice
  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fl_match));

endmodule

// File: rtl/vipt_way.sv
`timescale 1ns/1ps
module vipt_way #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int WORD_W = 32,
  parameter int WPL    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_valid,
  output logic [TAG_W-1:0]        rd_tag,
  output logic [WPL*WORD_W-1:0]   rd_line,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WPL*WORD_W-1:0]   fill_line,
  input  logic                    word_we,
  input  logic [IDX_W-1:0]        word_idx,
  input  logic [$clog2(WPL)-1:0]  word_sel,
  input  logic [WORD_W-1:0]       word_data
);
  localparam int SETS = 1 << IDX_W;
  localparam int WS_W = $clog2(WPL);

  logic [SETS-1:0]  vbits;
  logic [TAG_W-1:0] tag_mem [SETS];

  // valid bits live in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (fill_en) vbits[fill_idx] <= 1'b1;
      if (rd_en)   rd_valid <= vbits[rd_idx];
    end
  end

  // tag array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
    if (rd_en)   rd_tag <= tag_mem[rd_idx];
  end

  // data: one narrow RAM per word so a store touches only its word
  for (genvar k = 0; k < WPL; k++) begin : g_word
    logic [WORD_W-1:0] mem [SETS];
    logic [WORD_W-1:0] q;
    logic              we_k;
    logic [IDX_W-1:0]  wi;
    logic [WORD_W-1:0] wd;

    assign we_k = fill_en || (word_we && (word_sel == WS_W'(k)));
    assign wi   = fill_en ? fill_idx : word_idx;
    assign wd   = fill_en ? fill_line[k*WORD_W +: WORD_W] : word_data;

    always_ff @(posedge clk) begin
      if (we_k)  mem[wi] <= wd;
      if (rd_en) q <= mem[rd_idx];
    end

    assign rd_line[k*WORD_W +: WORD_W] = q;
  end

  // R7: a filled set reads back as valid from the next cycle on
  p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vbits[$past(fill_idx)]);

endmodule

// File: rtl/vipt_lru.sv
`timescale 1ns/1ps
module vipt_lru
  import vipt_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int WAYS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hit_en,
  input  logic [SET_W-1:0]        hit_idx,
  input  logic [$clog2(WAYS)-1:0] hit_way,
  input  logic                    fill_en,
  input  logic [SET_W-1:0]        fill_idx,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int SETS = 1 << SET_W;
  localparam int LW   = $clog2(WAYS);

  // per set: the way to replace next
  logic [LW-1:0] age_q [SETS];

  assign victim = age_q[fill_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (fill_en) begin
      age_q[fill_idx] <= LW'(wrap_inc(int'(victim), WAYS));
    end else if (hit_en) begin
      age_q[hit_idx] <= LW'(wrap_inc(int'(hit_way), WAYS));
    end
  end

  // R8: after a hit the hitting way is no longer the replacement choice
  p_hit_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !fill_en) |=> (age_q[$past(hit_idx)] != $past(hit_way)));

endmodule

// File: rtl/vipt_cache.sv
`timescale 1ns/1ps
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BYTES  = 16,
  parameter int WORD_W      = 32,
  parameter int WAYS        = 2,
  parameter int TLB_ENTRIES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [VA_W-1:0]                      req_vaddr,
  input  logic                                 req_write,
  input  logic [WORD_W-1:0]                    req_wdata,
  input  logic                                 tlb_fill_valid,
  input  logic [VA_W-PAGE_BITS-1:0]            tlb_fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0]            tlb_fill_ppn,
  input  logic                                 line_fill_valid,
  input  logic [PA_W-$clog2(LINE_BYTES)-1:0]   line_fill_laddr,
  input  logic [LINE_BYTES*8-1:0]              line_fill_data,
  output logic                                 resp_valid,
  output logic                                 resp_hit,
  output logic                                 resp_miss,
  output logic                                 resp_tlb_miss,
  output logic [WORD_W-1:0]                    resp_rdata,
  output logic [PA_W-1:0]                      resp_paddr
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = PAGE_BITS - OFF_W;      // index fits inside the page offset
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WPL    = LINE_W / WORD_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WS_W   = OFF_W - BYTE_W;
  localparam int WAY_W  = $clog2(WAYS);

  // ---------------- request hold / replay ----------------
  hold_st_t          st_q;
  logic [VA_W-1:0]   held_va;
  logic              held_wr;
  logic [WORD_W-1:0] held_wd;

  logic              s1_valid;
  logic [VA_W-1:0]   s1_va;
  logic              s1_write;
  logic [WORD_W-1:0] s1_wdata;
  logic              s1_tlb_hit;
  logic [PPN_W-1:0]  s1_ppn;

  logic              lk_valid;
  logic [VA_W-1:0]   lk_va;
  logic              lk_wr;
  logic [WORD_W-1:0] lk_wd;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;

  assign req_ready = (st_q == ST_RUN) && !line_fill_valid &&
                     !(s1_valid && (s1_write || !s1_tlb_hit));

  assign lk_valid = (st_q == ST_REPLAY) || (req_valid && req_ready);
  assign lk_va    = (st_q == ST_REPLAY) ? held_va : req_vaddr;
  assign lk_wr    = (st_q == ST_REPLAY) ? held_wr : req_write;
  assign lk_wd    = (st_q == ST_REPLAY) ? held_wd : req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      held_va <= '0;
      held_wr <= 1'b0;
      held_wd <= '0;
    end else begin
      case (st_q)
        ST_RUN:
          if (s1_valid && !s1_tlb_hit) begin
            held_va <= s1_va;
            held_wr <= s1_write;
            held_wd <= s1_wdata;
            st_q    <= tlb_fill_valid ? ST_REPLAY : ST_HOLD;
          end
        ST_HOLD:   if (tlb_fill_valid) st_q <= ST_REPLAY;
        ST_REPLAY: st_q <= ST_RUN;
        default:   st_q <= ST_RUN;
      endcase
    end
  end

  // ---------------- stage 0: translate while arrays read ----------------
  vipt_tlb #(
    .ENTRIES(TLB_ENTRIES),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W)
  ) u_tlb (
    .clk       (clk),
    .rst       (rst),
    .lk_vpn    (lk_va[VA_W-1:PAGE_BITS]),
    .lk_hit    (tlb_hit),
    .lk_ppn    (tlb_ppn),
    .fill_valid(tlb_fill_valid),
    .fill_vpn  (tlb_fill_vpn),
    .fill_ppn  (tlb_fill_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_va      <= '0;
      s1_write   <= 1'b0;
      s1_wdata   <= '0;
      s1_tlb_hit <= 1'b0;
      s1_ppn     <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) begin
        s1_va      <= lk_va;
        s1_write   <= lk_wr;
        s1_wdata   <= lk_wd;
        s1_tlb_hit <= tlb_hit;
        s1_ppn     <= tlb_ppn;
      end
    end
  end

  // ---------------- ways ----------------
  logic [IDX_W-1:0]  s1_idx;
  logic [WS_W-1:0]   s1_wsel;
  logic [IDX_W-1:0]  fl_idx;
  logic [PPN_W-1:0]  fl_tag;
  logic [WAY_W-1:0]  victim;
  logic [WAYS-1:0]   hit_vec;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way;
  logic              wr_hit;

  logic              way_v    [WAYS];
  logic [PPN_W-1:0]  way_tag  [WAYS];
  logic [LINE_W-1:0] way_line [WAYS];

  assign s1_idx  = s1_va[PAGE_BITS-1:OFF_W];
  assign s1_wsel = s1_va[OFF_W-1:BYTE_W];
  assign fl_idx  = line_fill_laddr[IDX_W-1:0];
  assign fl_tag  = line_fill_laddr[PA_W-OFF_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way #(
      .IDX_W (IDX_W),
      .TAG_W (PPN_W),
      .WORD_W(WORD_W),
      .WPL   (WPL)
    ) u_way (
      .clk      (clk),
      .rst      (rst),
      .rd_en    (lk_valid),
      .rd_idx   (lk_va[PAGE_BITS-1:OFF_W]),
      .rd_valid (way_v[w]),
      .rd_tag   (way_tag[w]),
      .rd_line  (way_line[w]),
      .fill_en  (line_fill_valid && (victim == WAY_W'(w))),
      .fill_idx (fl_idx),
      .fill_tag (fl_tag),
      .fill_line(line_fill_data),
      .word_we  (wr_hit && (hit_way == WAY_W'(w))),
      .word_idx (s1_idx),
      .word_sel (s1_wsel),
      .word_data(s1_wdata)
    );

    // stage 1: physical tag compare
    assign hit_vec[w] = s1_valid && s1_tlb_hit && way_v[w] && (way_tag[w] == s1_ppn);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign any_hit = |hit_vec;
  assign wr_hit  = any_hit && s1_write;

  vipt_lru #(
    .SET_W(IDX_W),
    .WAYS (WAYS)
  ) u_lru (
    .clk     (clk),
    .rst     (rst),
    .hit_en  (any_hit),
    .hit_idx (s1_idx),
    .hit_way (hit_way),
    .fill_en (line_fill_valid),
    .fill_idx(fl_idx),
    .victim  (victim)
  );

  // ---------------- registered response ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_miss     <= 1'b0;
      resp_tlb_miss <= 1'b0;
      resp_rdata    <= '0;
      resp_paddr    <= '0;
    end else begin
      resp_valid    <= s1_valid;
      resp_hit      <= any_hit;
      resp_miss     <= s1_valid && s1_tlb_hit && !any_hit;
      resp_tlb_miss <= s1_valid && !s1_tlb_hit;
      resp_rdata    <= (any_hit && !s1_write) ?
                       way_line[hit_way][int'(s1_wsel)*WORD_W +: WORD_W] : '0;
      resp_paddr    <= (s1_valid && s1_tlb_hit) ?
                       {s1_ppn, s1_va[PAGE_BITS-1:0]} : '0;
    end
  end

  // R2: every accepted request is answered two edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 resp_valid);

  // R5: one response kind per response, none without a response
  p_resp_kind_r5: assert property (@(posedge clk) disable iff (rst)
    $countones({resp_hit, resp_miss, resp_tlb_miss}) == (resp_valid ? 1 : 0));

  // R5: nothing is accepted while a translation miss is held or replayed
  p_hold_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN) |-> !req_ready);

  // R10: a store costs one bubble
  p_store_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> !req_ready);

  // R11: an untranslated response carries no address and no data
  p_tlbmiss_empty_r11: assert property (@(posedge clk) disable iff (rst)
    resp_tlb_miss |-> (resp_paddr == '0 && resp_rdata == '0));

endmodule

// File: tb/tb_vipt_cache.sv
`timescale 1ns/1ps
module tb_vipt_cache;

  logic         clk;
  logic         rst;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_vaddr;
  logic         req_write;
  logic [31:0]  req_wdata;
  logic         tlb_fill_valid;
  logic [19:0]  tlb_fill_vpn;
  logic [19:0]  tlb_fill_ppn;
  logic         line_fill_valid;
  logic [27:0]  line_fill_laddr;
  logic [127:0] line_fill_data;
  logic         resp_valid;
  logic         resp_hit;
  logic         resp_miss;
  logic         resp_tlb_miss;
  logic [31:0]  resp_rdata;
  logic [31:0]  resp_paddr;

  vipt_cache dut (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .req_write      (req_write),
    .req_wdata      (req_wdata),
    .tlb_fill_valid (tlb_fill_valid),
    .tlb_fill_vpn   (tlb_fill_vpn),
    .tlb_fill_ppn   (tlb_fill_ppn),
    .line_fill_valid(line_fill_valid),
    .line_fill_laddr(line_fill_laddr),
    .line_fill_data (line_fill_data),
    .resp_valid     (resp_valid),
    .resp_hit       (resp_hit),
    .resp_miss      (resp_miss),
    .resp_tlb_miss  (resp_tlb_miss),
    .resp_rdata     (resp_rdata),
    .resp_paddr     (resp_paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // response kinds as {hit, miss, tlb_miss}
  localparam logic [2:0] K_HIT = 3'b100;
  localparam logic [2:0] K_MIS = 3'b010;
  localparam logic [2:0] K_TLB = 3'b001;

  // captured response and handshake observations
  logic        r_v, r_early, r_rdy1;
  logic [2:0]  r_kind;
  logic [31:0] r_data, r_pa;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] lword(input logic [31:0] pa, input int k);
    return {pa[31:4], 4'(k * 4)} ^ 32'hC3C3_0000;
  endfunction

  function automatic logic [127:0] lline(input logic [31:0] pa);
    return {lword(pa, 3), lword(pa, 2), lword(pa, 1), lword(pa, 0)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    r_v    = resp_valid;
    r_kind = {resp_hit, resp_miss, resp_tlb_miss};
    r_data = resp_rdata;
    r_pa   = resp_paddr;
  endtask

  // one request; returns at the negedge after the response edge
  task automatic access(input logic [31:0] va, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_early   = resp_valid;
    r_rdy1    = req_ready;
    @(posedge clk);
    @(negedge clk);
    capture();
  endtask

  task automatic tlb_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    tlb_fill_valid = 1'b1;
    tlb_fill_vpn   = vpn;
    tlb_fill_ppn   = ppn;
    @(posedge clk);
    @(negedge clk);
    tlb_fill_valid = 1'b0;
  endtask

  task automatic line_fill(input logic [31:0] pa);
    @(negedge clk);
    line_fill_valid = 1'b1;
    line_fill_laddr = pa[31:4];
    line_fill_data  = lline(pa);
    #1;
    check("R10 ready during line fill", {31'd0, req_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    line_fill_valid = 1'b0;
  endtask

  // after a translation fill releases a held request, wait for its response
  task automatic wait_replay();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    capture();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_tlb_miss_replay();
    access(32'h0000_1230, 1'b0, '0);
    check("R1 R5 first lookup kind", {29'd0, r_kind}, {29'd0, K_TLB});
    check("R11 paddr on tlb miss", r_pa, 32'd0);
    check("R5 ready low while held", {31'd0, req_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R5 ready still low", {31'd0, req_ready}, 32'd0);
    tlb_fill(20'h00001, 20'h00080);
    wait_replay();
    check("R5 replay response valid", {31'd0, r_v}, 32'd1);
    check("R1 R5 replay kind miss", {29'd0, r_kind}, {29'd0, K_MIS});
    check("R11 replay paddr", r_pa, 32'h0008_0230);
    check("R11 miss rdata", r_data, 32'd0);
    @(negedge clk);
    check("R5 ready back after replay", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_fill_hit();
    line_fill(32'h0008_0230);
    access(32'h0000_1234, 1'b0, '0);
    check("R2 no response after one edge", {31'd0, r_early}, 32'd0);
    check("R2 response after two edges", {31'd0, r_v}, 32'd1);
    check("R7 hit kind", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R3 R7 word 1 data", r_data, lword(32'h0008_0230, 1));
  endtask

  task automatic t_synonym();
    tlb_fill(20'h00055, 20'h00080);
    access(32'h0005_5238, 1'b0, '0);
    check("R3 synonym kind", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R3 synonym word 2", r_data, lword(32'h0008_0230, 2));
    check("R11 synonym paddr", r_pa, 32'h0008_0238);
  endtask

  task automatic t_ppn_mismatch();
    tlb_fill(20'h00002, 20'h00090);
    access(32'h0000_2230, 1'b0, '0);
    check("R4 other page same set misses", {29'd0, r_kind}, {29'd0, K_MIS});
    check("R11 miss rdata zero", r_data, 32'd0);
    check("R11 miss paddr", r_pa, 32'h0009_0230);
  endtask

  task automatic t_lru();
    line_fill(32'h0009_0230);
    access(32'h0000_2230, 1'b0, '0);
    check("R7 second way hit", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R7 second way data", r_data, lword(32'h0009_0230, 0));
    access(32'h0000_1230, 1'b0, '0);
    check("R8 first line still hit", {29'd0, r_kind}, {29'd0, K_HIT});
    tlb_fill(20'h00003, 20'h000A0);
    line_fill(32'h000A_0230);
    access(32'h0000_3230, 1'b0, '0);
    check("R8 new line hit", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R8 new line data", r_data, lword(32'h000A_0230, 0));
    access(32'h0000_1230, 1'b0, '0);
    check("R8 recently used line kept", {29'd0, r_kind}, {29'd0, K_HIT});
    access(32'h0000_2230, 1'b0, '0);
    check("R8 least recent line evicted", {29'd0, r_kind}, {29'd0, K_MIS});
  endtask

  task automatic t_write_hit();
    access(32'h0000_1234, 1'b1, 32'hDEAD_BEEF);
    check("R9 store hit kind", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R9 store rdata zero", r_data, 32'd0);
    check("R10 ready low after store", {31'd0, r_rdy1}, 32'd0);
    access(32'h0000_1234, 1'b0, '0);
    check("R9 stored word read back", r_data, 32'hDEAD_BEEF);
    access(32'h0000_1238, 1'b0, '0);
    check("R9 neighbour word intact", r_data, lword(32'h0008_0230, 2));
    access(32'h0005_5234, 1'b0, '0);
    check("R3 R9 synonym sees store", r_data, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_miss();
    access(32'h0000_2234, 1'b1, 32'h1234_5678);
    check("R9 store miss kind", {29'd0, r_kind}, {29'd0, K_MIS});
    access(32'h0000_2234, 1'b0, '0);
    check("R9 store miss allocates nothing", {29'd0, r_kind}, {29'd0, K_MIS});
    access(32'h0000_3234, 1'b0, '0);
    check("R9 other line untouched", r_data, lword(32'h000A_0230, 1));
    access(32'h0000_1234, 1'b0, '0);
    check("R9 first line untouched", r_data, 32'hDEAD_BEEF);
  endtask

  task automatic t_tlb_overwrite();
    tlb_fill(20'h00002, 20'h000A0);
    access(32'h0000_2234, 1'b0, '0);
    check("R6 overwritten entry kind", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R6 overwritten entry data", r_data, lword(32'h000A_0230, 1));
    check("R6 overwritten entry paddr", r_pa, 32'h000A_0234);
  endtask

  task automatic t_tlb_capacity();
    // entries 0..3 hold pages 1, 0x55, 2, 3; fill entries 4..7
    for (int i = 0; i < 4; i++) tlb_fill(20'(32'h100 + i), 20'(32'h300 + i));
    access(32'h0010_3230, 1'b0, '0);
    check("R6 eighth entry translates", r_pa, 32'h0030_3230);
    tlb_fill(20'h00200, 20'h000A0);
    access(32'h0020_0230, 1'b0, '0);
    check("R6 replacement entry hit", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R6 replacement entry data", r_data, lword(32'h000A_0230, 0));
    access(32'h0000_1230, 1'b0, '0);
    check("R6 entry 0 replaced first", {29'd0, r_kind}, {29'd0, K_TLB});
    tlb_fill(20'h00001, 20'h00080);
    wait_replay();
    check("R5 R6 replay after refill", {29'd0, r_kind}, {29'd0, K_HIT});
    check("R5 replay data", r_data, lword(32'h0008_0230, 0));
    access(32'h0005_5230, 1'b0, '0);
    check("R6 rotation reached entry 1", {29'd0, r_kind}, {29'd0, K_TLB});
    tlb_fill(20'h00055, 20'h00080);
    wait_replay();
    check("R5 second replay hit", {29'd0, r_kind}, {29'd0, K_HIT});
  endtask

  initial begin
    rst             = 1'b1;
    req_valid       = 1'b0;
    req_vaddr       = '0;
    req_write       = 1'b0;
    req_wdata       = '0;
    tlb_fill_valid  = 1'b0;
    tlb_fill_vpn    = '0;
    tlb_fill_ppn    = '0;
    line_fill_valid = 1'b0;
    line_fill_laddr = '0;
    line_fill_data  = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    t_reset();
    t_tlb_miss_replay();
    t_fill_hit();
    t_synonym();
    t_ppn_mismatch();
    t_lru();
    t_write_hit();
    t_write_miss();
    t_tlb_overwrite();
    t_tlb_capacity();

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule